// File: doc/BRIEF.md
# Resizable Banked Reorder Buffer

This block is a circular reorder buffer made of equal-size banks. Its active capacity follows the operating mode of a core that changes shape at run time. Entries are allocated in order at the tail. An entry is marked complete by its tag, and the block retires entries in order from the head, one per cycle, once the head entry is complete.

A mode request changes how many banks are in use. Each bank that is out of use raises its power-gate output. The active mode also sets the fetch width and the enabled decode lanes.

Growing powers the extra banks at once. The wrap point moves only when the buffer is empty or when the tail reaches the end of the old range. At that moment the live region cannot wrap, so the tail continues into the new banks.

Shrinking stalls allocation until every live entry lies below the new limit without wrapping. The new limit then takes effect. An empty buffer has both its pointers rebased to zero.

Top module: `rob_bank_resize`

## Requirements
- R1: After reset the mode is 3, all banks are powered (`bank_pg` all zero), `count` is 0, `empty` is 1, `full` is 0, `fetch_width` is 4 and `decode_lane_en` is 4'b1111.
- R2: An allocation handed out while `alloc_ready` is 1 receives tag `alloc_tag`. Tags run consecutively and wrap from capacity-1 to 0. `alloc_ready` is 0 while the buffer is full, and a request made then changes nothing.
- R3: A completion for a tag that holds a live entry marks that entry done. A completion for a tag with no live entry is ignored. `retire_vld` is high, with `retire_tag` equal to the head, only when the head entry is done. Retirement is strictly in allocation order.
- R4: The mode code sets the capacity and the front end: code 0 gives 16 entries, width 1 and lanes 4'b0001. Code 1 gives 64 entries, width 2 and lanes 4'b0011. Code 2 gives 128 entries, width 4 and lanes 4'b1111. Code 3 gives 256 entries, width 4 and lanes 4'b1111. Each bank holds 16 entries, and bank i is gated exactly when i is at or above the number of banks in use.
- R5: On a grow request, the extra banks drop their gate on the cycle after the request. The new capacity takes effect only when the buffer is empty, or when an allocation lands on the last entry of the old range. In the second case the next tag is the old capacity.
- R6: On a shrink request, `alloc_ready` is 0 until all live entries fit below the new capacity without wrapping. The new capacity then takes effect, and gates rise on the removed banks. If the buffer was empty, the next tag is 0.
- R7: `resize_ack` is high for exactly one cycle, in the cycle in which the new mode's capacity, width and gates are first visible. A mode request made while an earlier one is pending is ignored.
- R8: `count`, `full` and `empty` are always computed against the active capacity.
- R9: A bank whose gate is raised holds no live entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request to allocate one entry |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_tag | output | 8 | Tag given to the allocation |
| cmpl_vld | input | 1 | Completion strobe |
| cmpl_tag | input | 8 | Tag of the completed entry |
| retire_vld | output | 1 | Head entry retires this cycle |
| retire_tag | output | 8 | Tag of the retiring entry |
| mode_req_vld | input | 1 | Mode change request strobe |
| mode_req | input | 2 | Requested mode code |
| resize_ack | output | 1 | One-cycle pulse when the new mode takes effect |
| bank_pg | output | 16 | Per-bank power-gate, 1 means gated |
| count | output | 9 | Live entries |
| full | output | 1 | Count equals active capacity |
| empty | output | 1 | No live entries |
| fetch_width | output | 3 | Fetch width of the active mode |
| decode_lane_en | output | 4 | Enabled decode lanes |

## Verification
Growth can take effect in the very cycle an allocation lands on the last entry of the old range. Both the pointer step and the wrap-point change then act on one edge. The bench provokes this by filling the small mode to one short of its end with a grow pending. It then judges that the acknowledge, the wider fetch and the next tag of 16 all appear together.

A shrink also meets retirement in the same cycle. The bench stalls a shrink behind entries in a bank that is being removed and drains them. It checks that the capacity switches only after the last retirement and that the tags then restart at zero.

// File: rtl/rob_bank_resize.sv
module rob_bank_resize #(
  parameter int NBANKS = 16,
  parameter int BANK = 16,
  parameter logic [1:0] RST_MODE = 2'd3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  alloc_req,
  output logic                                  alloc_ready,
  output logic [$clog2(NBANKS*BANK)-1:0]        alloc_tag,
  input  logic                                  cmpl_vld,
  input  logic [$clog2(NBANKS*BANK)-1:0]        cmpl_tag,
  output logic                                  retire_vld,
  output logic [$clog2(NBANKS*BANK)-1:0]        retire_tag,
  input  logic                                  mode_req_vld,
  input  logic [1:0]                            mode_req,
  output logic                                  resize_ack,
  output logic [NBANKS-1:0]                     bank_pg,
  output logic [$clog2(NBANKS*BANK):0]          count,
  output logic                                  full,
  output logic                                  empty,
  output logic [2:0]                            fetch_width,
  output logic [3:0]                            decode_lane_en
);
  localparam int MAXE = NBANKS * BANK;
  localparam int PW = $clog2(MAXE);
  localparam int CW = PW + 1;
  localparam int BW = $clog2(NBANKS) + 1;

  function automatic logic [BW-1:0] banks_of(input logic [1:0] m);
    case (m)
      2'd0: banks_of = BW'(1);
      2'd1: banks_of = BW'(NBANKS / 4);
      2'd2: banks_of = BW'(NBANKS / 2);
      default: banks_of = BW'(NBANKS);
    endcase
  endfunction

  logic [MAXE-1:0] vld, dn;
  logic [PW-1:0] head, tail, head_inc, tail_inc;
  logic [CW-1:0] cnt, cap_e, tgt_e, nxt_e;
  logic [1:0] mode_q, tgt_mode;
  logic pend, ack_q;
  logic [BW-1:0] cap_b, tgt_b, en_b;
  logic grow, shrinking, alloc_fire, tail_end, apply, rebase;

  assign cap_b = banks_of(mode_q);
  assign tgt_b = banks_of(tgt_mode);
  assign cap_e = CW'(cap_b) * CW'(BANK);
  assign tgt_e = CW'(tgt_b) * CW'(BANK);
  assign grow = tgt_b >= cap_b;
  assign shrinking = pend && !grow;

  assign full = cnt == cap_e;
  assign empty = cnt == '0;
  assign count = cnt;
  assign alloc_ready = !full && !shrinking;
  assign alloc_fire = alloc_req && alloc_ready;
  assign alloc_tag = tail;
  assign retire_vld = vld[head] && dn[head];
  assign retire_tag = head;
  assign resize_ack = ack_q;

  assign tail_end = tail == PW'(cap_e - CW'(1));
  always_comb begin
    apply = 1'b0;
    if (pend) begin
      if (grow)
        apply = (empty && !alloc_fire) || (tgt_b == cap_b) || (alloc_fire && tail_end);
      else
        apply = empty || (({1'b0, head} + cnt) <= tgt_e);
    end
  end
  assign rebase = apply && empty && !alloc_fire;
  assign nxt_e = apply ? tgt_e : cap_e;
  assign head_inc = (head == PW'(nxt_e - CW'(1))) ? '0 : head + PW'(1);
  assign tail_inc = (tail == PW'(nxt_e - CW'(1))) ? '0 : tail + PW'(1);

  assign en_b = (pend && grow) ? tgt_b : cap_b;
  for (genvar i = 0; i < NBANKS; i++) begin : g_pg
    assign bank_pg[i] = BW'(i) >= en_b;
    a_r9_gated_bank_empty: assert property (@(posedge clk) disable iff (!rst_n)
      bank_pg[i] |-> (vld[i*BANK +: BANK] == '0));
  end

  assign fetch_width = (mode_q == 2'd0) ? 3'd1 : (mode_q == 2'd1) ? 3'd2 : 3'd4;
  assign decode_lane_en = (mode_q == 2'd0) ? 4'b0001 : (mode_q == 2'd1) ? 4'b0011 : 4'b1111;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      dn <= '0;
      head <= '0;
      tail <= '0;
      cnt <= '0;
      mode_q <= RST_MODE;
      tgt_mode <= RST_MODE;
      pend <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= apply;
      if (mode_req_vld && !pend) begin
        pend <= 1'b1;
        tgt_mode <= mode_req;
      end
      if (apply) begin
        pend <= 1'b0;
        mode_q <= tgt_mode;
      end
      if (cmpl_vld && vld[cmpl_tag]) dn[cmpl_tag] <= 1'b1;
      if (alloc_fire) begin
        vld[tail] <= 1'b1;
        dn[tail] <= 1'b0;
        tail <= tail_inc;
      end
      if (retire_vld) begin
        vld[head] <= 1'b0;
        head <= head_inc;
      end
      cnt <= cnt + CW'(alloc_fire) - CW'(retire_vld);
      if (rebase) begin
        head <= '0;
        tail <= '0;
      end else if (apply && !grow && tail == PW'(tgt_e)) begin
        tail <= '0;
      end
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap_e);
  a_r6_no_growth_in_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    shrinking |=> cnt <= $past(cnt));
  a_r3_no_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !retire_vld);
  a_r7_ack_after_pending: assert property (@(posedge clk) disable iff (!rst_n)
    resize_ack |-> $past(pend));
endmodule

// File: tb/rob_bank_resize_tb.sv
module rob_bank_resize_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_req = 1'b0, cmpl_vld = 1'b0, mode_req_vld = 1'b0;
  logic [7:0] cmpl_tag = '0;
  logic [1:0] mode_req = '0;
  logic alloc_ready, retire_vld, resize_ack, full, empty;
  logic [7:0] alloc_tag, retire_tag;
  logic [15:0] bank_pg;
  logic [8:0] count;
  logic [2:0] fetch_width;
  logic [3:0] decode_lane_en;
  int ncheck = 0, nfail = 0;

  always #4 clk = ~clk;

  rob_bank_resize u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .cmpl_vld(cmpl_vld), .cmpl_tag(cmpl_tag),
    .retire_vld(retire_vld), .retire_tag(retire_tag), .mode_req_vld(mode_req_vld),
    .mode_req(mode_req), .resize_ack(resize_ack), .bank_pg(bank_pg), .count(count),
    .full(full), .empty(empty), .fetch_width(fetch_width), .decode_lane_en(decode_lane_en)
  );

  // mode, capacity, fetch width, lanes
  localparam int TBL [4][4] = '{
    '{0, 16, 1, 1}, '{2, 128, 4, 15}, '{1, 64, 2, 3}, '{3, 256, 4, 15}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    ncheck++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_mode(input int m);
    mode_req_vld = 1'b1;
    mode_req = 2'(m);
    @(negedge clk);
    mode_req_vld = 1'b0;
  endtask

  task automatic wait_ack(input string req);
    bit got = 0;
    for (int n = 0; n < 8 && !got; n++) begin
      if (resize_ack) got = 1;
      else @(negedge clk);
    end
    check(got, req, int'(got), 1);
  endtask

  task automatic alloc_n(input int n, input int first, input int cap);
    for (int i = 0; i < n; i++) begin
      check(alloc_ready, "R2 ready", int'(alloc_ready), 1);
      check(alloc_tag == 8'((first + i) % cap), "R2 tag", int'(alloc_tag), (first + i) % cap);
      alloc_req = 1'b1;
      @(negedge clk);
      alloc_req = 1'b0;
    end
  endtask

  task automatic drain(input int first, input int n, input int cap);
    for (int k = n - 1; k >= 0; k--) begin
      check(!retire_vld, "R3 no early retire", int'(retire_vld), 0);
      cmpl_vld = 1'b1;
      cmpl_tag = 8'((first + k) % cap);
      @(negedge clk);
    end
    cmpl_vld = 1'b0;
    for (int k = 0; k < n; k++) begin
      check(retire_vld && retire_tag == 8'((first + k) % cap), "R3 retire order",
            int'(retire_tag), (first + k) % cap);
      @(negedge clk);
    end
    check(empty && count == 0, "R8 empty after drain", int'(count), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(bank_pg == 16'h0, "R1 banks on", int'(bank_pg), 0);
    check(empty && !full && count == 0, "R1 empty", int'(count), 0);
    check(fetch_width == 3'd4 && decode_lane_en == 4'b1111, "R1 width", int'(fetch_width), 4);

    foreach (TBL[t]) begin
      pulse_mode(TBL[t][0]);
      wait_ack("R7 ack");
      @(negedge clk);
      check(!resize_ack, "R7 single pulse", int'(resize_ack), 0);
      check($countones(~bank_pg) * 16 == TBL[t][1], "R4 capacity", $countones(~bank_pg) * 16, TBL[t][1]);
      check(int'(fetch_width) == TBL[t][2], "R4 fetch width", int'(fetch_width), TBL[t][2]);
      check(int'(decode_lane_en) == TBL[t][3], "R4 lanes", int'(decode_lane_en), TBL[t][3]);
      alloc_n(TBL[t][1], 0, TBL[t][1]);
      check(full && !alloc_ready && int'(count) == TBL[t][1], "R8 full", int'(count), TBL[t][1]);
      drain(0, TBL[t][1], TBL[t][1]);
    end

    // R5: deferred growth
    pulse_mode(0);
    wait_ack("R6 empty shrink ack");
    @(negedge clk);
    alloc_n(10, 0, 16);
    pulse_mode(1);
    check($countones(bank_pg) == 12, "R5 banks on early", $countones(bank_pg), 12);
    check(!resize_ack && fetch_width == 3'd1, "R5 not yet effective", int'(fetch_width), 1);
    alloc_n(5, 10, 16);
    check(!resize_ack, "R5 waits for tail end", int'(resize_ack), 0);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    check(resize_ack && fetch_width == 3'd2, "R5 effective at tail end", int'(fetch_width), 2);
    check(alloc_tag == 8'd16 && !full && count == 16, "R5 tail continues", int'(alloc_tag), 16);
    alloc_n(1, 16, 64);
    drain(0, 17, 64);

    // R6: shrink stalls behind entries in a removed bank; R7 second request ignored
    alloc_n(3, 17, 64);
    pulse_mode(0);
    check(!alloc_ready && !resize_ack && count == 3, "R6 stall", int'(alloc_ready), 0);
    check($countones(bank_pg) == 12, "R6 banks still on", $countones(bank_pg), 12);
    pulse_mode(3);
    drain(17, 3, 64);
    check(!resize_ack, "R6 not before drain", int'(resize_ack), 0);
    wait_ack("R6 ack after drain");
    check(fetch_width == 3'd1 && $countones(bank_pg) == 15, "R7 later request ignored", int'(fetch_width), 1);
    check(alloc_tag == 8'd0 && alloc_ready, "R6 rebased", int'(alloc_tag), 0);
    @(negedge clk);

    // R6: non-empty shrink that already fits
    pulse_mode(1);
    wait_ack("R5 empty grow ack");
    @(negedge clk);
    alloc_n(4, 0, 64);
    pulse_mode(0);
    wait_ack("R6 fitting shrink ack");
    check(count == 4 && alloc_tag == 8'd4 && fetch_width == 3'd1, "R6 entries kept", int'(alloc_tag), 4);
    @(negedge clk);
    drain(0, 4, 16);

    // R3: completion of a dead tag is ignored
    alloc_n(1, 4, 16);
    cmpl_vld = 1'b1;
    cmpl_tag = 8'd9;
    @(negedge clk);
    cmpl_vld = 1'b0;
    @(negedge clk);
    check(!retire_vld && count == 1, "R3 dead tag ignored", int'(retire_vld), 0);
    drain(4, 1, 16);

    // R2/R8: wrap and full in the smallest mode
    alloc_n(16, 5, 16);
    check(full && !alloc_ready, "R8 full at 16", int'(count), 16);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    check(count == 16 && alloc_tag == 8'd5, "R2 request when full ignored", int'(count), 16);
    drain(5, 16, 16);

    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule